// File: doc/BRIEF.md
# Wake-Up Pulse Window Detector

This block watches a single digital feedback line. The line is wired back from one of two switching output channels. A remote device asks for attention by briefly forcing that line to the opposite of the level the chip is driving. The detector measures how long each such reversal lasts, in clock cycles. It accepts the reversal as a wake-up request only when the measured width lies inside a window set by parameters.

An accepted request sets a sticky status flag. The same flag drives an active-low diagnostic pin. The flag stays set until a host read strobe clears it.

Detection is armed by an enable bit. A select bit chooses which channel's driven level and mode field apply. Detection is blocked when the selected channel's 2-bit mode field is zero. The output-disable input has no effect on detection.

Top module: `wkp_detect_top`

## Requirements
- R1: After reset, `req_status` is 0 and `diag_n` is 1.
- R2: A reversal whose width W cycles satisfies MIN_W <= W <= MAX_W is accepted. `req_status` becomes 1 and `diag_n` becomes 0 on the third rising clock edge after `fb_in` returns to the driven level.
- R3: A reversal shorter than MIN_W cycles is discarded and does not set the status.
- R4: A reversal longer than MAX_W cycles is discarded. This holds for reversals long enough to wrap a free-running width counter. The width count saturates at MAX_W+1.
- R5: While `det_en` is 0, no reversal sets the status.
- R6: `chan_sel` = 0 selects channel 1 and `chan_sel` = 1 selects channel 2. A reversal means that `fb_in` differs from the selected channel's drive level.
- R7: When the selected channel's mode field equals 2'b00, detection is blocked. A 2'b00 mode on the channel that is not selected does not block detection.
- R8: `outputs_off` has no effect on detection.
- R9: A high `status_rd` at a clock edge clears `req_status`. If an acceptance occurs at the same edge, the acceptance wins and the status stays 1.
- R10: Once set, the status stays set until a read strobe clears it. Further rejected pulses do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| det_en | input | 1 | Detection enable |
| chan_sel | input | 1 | Channel select: 0 for channel 1, 1 for channel 2 |
| ch1_mode | input | 2 | Channel 1 mode field; 2'b00 means off |
| ch2_mode | input | 2 | Channel 2 mode field; 2'b00 means off |
| ch1_drive | input | 1 | Level driven on channel 1 |
| ch2_drive | input | 1 | Level driven on channel 2 |
| outputs_off | input | 1 | Output disable; does not affect detection |
| fb_in | input | 1 | Asynchronous feedback line |
| status_rd | input | 1 | Host read strobe that clears the status |
| req_status | output | 1 | Sticky accepted-request flag |
| diag_n | output | 1 | Active-low diagnostic, low while the status is set |

## Verification
The feedback line and the selected drive level each pass through two synchronizer stages. The width counter then needs one more edge to see the line idle, so an acceptance shows on the outputs exactly at the third rising edge after the line is restored. A read strobe clears the status at the edge where it is sampled.

The bench drives all inputs on falling edges and samples outputs on falling edges. After restoring the line, it checks that the status is still unchanged after two rising edges. It then checks the expected value after the third edge. For rejected pulses it checks again a few cycles later. The same-edge priority test raises the read strobe so that it coincides with that third edge.

// File: rtl/wkp_pkg.sv
package wkp_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_LOW  = 2'b01,
        MODE_HIGH = 2'b10,
        MODE_PP   = 2'b11
    } chan_mode_e;

    typedef struct packed {
        logic drive;
        logic fb;
    } line_t;

    function automatic logic [1:0] pick_mode(input logic sel,
                                             input logic [1:0] m1,
                                             input logic [1:0] m2);
        return sel ? m2 : m1;
    endfunction

    function automatic logic in_window(input int unsigned w,
                                       input int unsigned lo,
                                       input int unsigned hi);
        return (w >= lo) && (w <= hi);
    endfunction

endpackage

// File: rtl/wkp_sync.sv
module wkp_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    input  logic [W-1:0] init,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= init;
            stage2 <= init;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/wkp_width_meter.sv
module wkp_width_meter #(
    parameter int MIN_W = 4,
    parameter int MAX_W = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic rev,
    output logic accept
);
    localparam int CNT_W = $clog2(MAX_W + 2);
    localparam logic [CNT_W-1:0] SAT_C = CNT_W'(MAX_W + 1);

    logic [CNT_W-1:0] cnt;
    logic             end_evt;

    always_ff @(posedge clk) begin
        if (rst || !armed) begin
            cnt <= '0;
        end else if (rev) begin
            if (cnt != SAT_C) cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

    assign end_evt = !rev && (cnt != '0);
    assign accept  = armed && end_evt &&
                     wkp_pkg::in_window(int'(cnt), MIN_W, MAX_W);

    // R4: counter never passes the saturation value
    always_ff @(posedge clk) begin
        if (!rst) p_no_overflow_r4: assert (cnt <= SAT_C);
    end

    // R3: accepted widths are never below the minimum
    p_min_width_r3: assert property (@(posedge clk) disable iff (rst)
        accept |-> (int'(cnt) >= MIN_W));
endmodule

// File: rtl/wkp_sticky.sv
module wkp_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    // R9: set wins over clear in the same cycle
    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);

    // R9: clear without set empties the flag
    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag);

    // R10: flag holds with no set and no clear
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!clr && !set) |=> $stable(flag));
endmodule

// File: rtl/wkp_detect_top.sv
module wkp_detect_top #(
    parameter int MIN_W = 4,
    parameter int MAX_W = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       det_en,
    input  logic       chan_sel,
    input  logic [1:0] ch1_mode,
    input  logic [1:0] ch2_mode,
    input  logic       ch1_drive,
    input  logic       ch2_drive,
    input  logic       outputs_off,
    input  logic       fb_in,
    input  logic       status_rd,
    output logic       req_status,
    output logic       diag_n
);
    import wkp_pkg::*;

    line_t      raw_line;
    line_t      sync_line;
    logic       rev;
    logic       armed;
    logic       accept;
    chan_mode_e sel_mode;

    assign raw_line.drive = chan_sel ? ch2_drive : ch1_drive;
    assign raw_line.fb    = fb_in;

    wkp_sync #(.W($bits(line_t))) u_sync (
        .clk  (clk),
        .rst  (rst),
        .d    (raw_line),
        .init ('0),
        .q    (sync_line)
    );

    assign rev      = sync_line.fb ^ sync_line.drive;
    assign sel_mode = chan_mode_e'(pick_mode(chan_sel, ch1_mode, ch2_mode));
    assign armed    = det_en && (sel_mode != MODE_OFF);

    wkp_width_meter #(.MIN_W(MIN_W), .MAX_W(MAX_W)) u_meter (
        .clk    (clk),
        .rst    (rst),
        .armed  (armed),
        .rev    (rev),
        .accept (accept)
    );

    wkp_sticky u_sticky (
        .clk  (clk),
        .rst  (rst),
        .set  (accept),
        .clr  (status_rd),
        .flag (req_status)
    );

    assign diag_n = ~req_status;

    // R5: status cannot rise while detection is disabled
    p_disabled_r5: assert property (@(posedge clk) disable iff (rst)
        !det_en |=> !$rose(req_status));

    // R7: status cannot rise while the selected mode is off
    p_mode_off_r7: assert property (@(posedge clk) disable iff (rst)
        (sel_mode == MODE_OFF) |=> !$rose(req_status));

    // R8: acceptance takes effect even with outputs disabled
    p_outputs_off_r8: assert property (@(posedge clk) disable iff (rst)
        (accept && outputs_off) |=> req_status);

    // R2: diagnostic pin mirrors the status inverted
    p_diag_r2: assert property (@(posedge clk) disable iff (rst)
        diag_n != req_status);
endmodule

// File: tb/sim_wkp_detect_top.sv
module sim_wkp_detect_top;
    localparam int CLK_P = 10;
    localparam int MIN_W = 4;
    localparam int MAX_W = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       det_en = 1'b0;
    logic       chan_sel = 1'b0;
    logic [1:0] ch1_mode = 2'b01;
    logic [1:0] ch2_mode = 2'b01;
    logic       ch1_drive = 1'b0;
    logic       ch2_drive = 1'b0;
    logic       outputs_off = 1'b0;
    logic       fb_in = 1'b0;
    logic       status_rd = 1'b0;
    logic       req_status;
    logic       diag_n;

    int n_checks = 0;
    int n_fail = 0;

    wkp_detect_top #(.MIN_W(MIN_W), .MAX_W(MAX_W)) u0 (
        .clk(clk), .rst(rst), .det_en(det_en), .chan_sel(chan_sel),
        .ch1_mode(ch1_mode), .ch2_mode(ch2_mode),
        .ch1_drive(ch1_drive), .ch2_drive(ch2_drive),
        .outputs_off(outputs_off), .fb_in(fb_in),
        .status_rd(status_rd), .req_status(req_status), .diag_n(diag_n)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Reverses the line for w cycles relative to idle level, then checks
    // that the status holds for two edges and takes exp on the third.
    task automatic pulse(input string req, input int w, input logic idle,
                         input logic prior, input logic exp);
        @(negedge clk) fb_in = ~idle;
        repeat (w) @(negedge clk);
        fb_in = idle;
        repeat (2) @(negedge clk);
        check(req, req_status, prior);
        @(negedge clk);
        check(req, req_status, exp);
        check(req, diag_n, ~exp);
        repeat (4) @(negedge clk);
        check(req, req_status, exp);
    endtask

    task automatic do_read();
        @(negedge clk) status_rd = 1'b1;
        @(negedge clk) status_rd = 1'b0;
        check("R9", req_status, 1'b0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", req_status, 1'b0);
        check("R1", diag_n, 1'b1);
    endtask

    task automatic t_window();
        det_en = 1'b1;
        @(negedge clk);
        pulse("R2", MIN_W, 1'b0, 1'b0, 1'b1);
        do_read();
        pulse("R2", MAX_W, 1'b0, 1'b0, 1'b1);
        do_read();
        pulse("R2", 7, 1'b0, 1'b0, 1'b1);
        do_read();
    endtask

    task automatic t_short_long();
        pulse("R3", MIN_W - 1, 1'b0, 1'b0, 1'b0);
        pulse("R3", 1, 1'b0, 1'b0, 1'b0);
        pulse("R4", MAX_W + 1, 1'b0, 1'b0, 1'b0);
        pulse("R4", 16 + 5, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_disabled();
        det_en = 1'b0;
        pulse("R5", 6, 1'b0, 1'b0, 1'b0);
        det_en = 1'b1;
    endtask

    task automatic t_channel2();
        @(negedge clk);
        chan_sel = 1'b1;
        ch2_drive = 1'b1;
        fb_in = 1'b1;
        repeat (5) @(negedge clk);
        check("R6", req_status, 1'b0);
        pulse("R6", 6, 1'b1, 1'b0, 1'b1);
        do_read();
        @(negedge clk);
        chan_sel = 1'b0;
        fb_in = 1'b0;
        repeat (5) @(negedge clk);
        check("R6", req_status, 1'b0);
    endtask

    task automatic t_mode();
        ch1_mode = 2'b00;
        pulse("R7", 6, 1'b0, 1'b0, 1'b0);
        ch1_mode = 2'b10;
        ch2_mode = 2'b00;
        pulse("R7", 6, 1'b0, 1'b0, 1'b1);
        do_read();
        ch2_mode = 2'b11;
    endtask

    task automatic t_outputs_off();
        outputs_off = 1'b1;
        pulse("R8", 5, 1'b0, 1'b0, 1'b1);
        do_read();
        outputs_off = 1'b0;
    endtask

    task automatic t_sticky_priority();
        pulse("R10", 6, 1'b0, 1'b0, 1'b1);
        pulse("R10", 2, 1'b0, 1'b1, 1'b1);
        pulse("R10", MAX_W + 3, 1'b0, 1'b1, 1'b1);
        // read strobe coincides with the acceptance edge
        @(negedge clk) fb_in = 1'b1;
        repeat (6) @(negedge clk);
        fb_in = 1'b0;
        @(negedge clk);
        @(negedge clk) status_rd = 1'b1;
        @(negedge clk) status_rd = 1'b0;
        check("R9", req_status, 1'b1);
        do_read();
    endtask

    initial begin
        #(CLK_P * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        t_reset();
        t_window();
        t_short_long();
        t_disabled();
        t_channel2();
        t_mode();
        t_outputs_off();
        t_sticky_priority();
        report();
    end
endmodule